// File: doc/BRIEF.md
# Dual-Strobe Decade Up/Down Counter

This block holds one BCD digit and steps it with two separate count strobes, one for each direction, instead of a direction bit. A strobe acts on its rising edge, and only while the opposite strobe sits high. Both strobes are asynchronous to the system clock. Each passes through a synchronizer before its edge is detected, so the whole block runs in one clock domain.

A parallel preset (active-low load with a four-bit value) and an active-high clear set the digit directly. Clear wins over load, and load wins over counting. Two active-low cascade outputs follow the low phase of the count strobe while the digit sits at its terminal value. Wiring the carry output of one stage to the up strobe of the next, and the borrow output to the down strobe, chains stages into a multi-digit counter with no glue logic.

Top module: `bcd_updown_counter`

## Requirements
- R1: A rising edge on the synchronized up strobe while the synchronized down strobe is high adds one to the digit, and 9 steps to 0.
- R2: A rising edge on the synchronized down strobe while the synchronized up strobe is high subtracts one from the digit, and 0 steps to 9.
- R3: With the default two synchronizer stages, a strobe change that is applied between clock edges moves the digit at the third rising clock edge after it, and moves the cascade outputs at the second.
- R4: While clear is high, the digit becomes 0 at the next clock edge, whatever load, the preset value and the strobes are doing.
- R5: While load is low and clear is low, the digit takes the preset value at the next clock edge, and strobe edges are ignored.
- R6: The digit holds its value when both strobes rise in the same cycle, or when one strobe rises while the other is low.
- R7: `carry_n` is low exactly while the digit is 9 and the synchronized up strobe is low. It is high otherwise, so its low pulse is as wide as the up strobe's low phase.
- R8: `borrow_n` is low exactly while the digit is 0 and the synchronized down strobe is low. It is high otherwise, so its low pulse is as wide as the down strobe's low phase.
- R9: A preset from 10 to 15 is loaded unchanged. From such a value an up step gives 0, and a down step subtracts one.
- R10: While `rst_n` is low, the digit is 0 and both synchronized strobes read high, so `carry_n` and `borrow_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_strobe | input | 1 | Count-up strobe, acts on its rising edge, asynchronous |
| dn_strobe | input | 1 | Count-down strobe, acts on its rising edge, asynchronous |
| load_n | input | 1 | Active-low parallel preset enable, synchronous |
| preset_val | input | 4 | Value taken while load_n is low |
| clr | input | 1 | Active-high clear, synchronous, highest priority |
| digit | output | 4 | Current BCD value |
| carry_n | output | 1 | Active-low cascade carry for the next stage's up strobe |
| borrow_n | output | 1 | Active-low cascade borrow for the next stage's down strobe |

## Verification
Every stimulus is applied on a falling clock edge. The bench then knows how many rising edges each result needs. Clear and load results are due one edge later. A strobe's effect on `carry_n` and `borrow_n` is due two edges later, after the synchronizer. Its effect on the digit is due three edges later, after edge detection. The driver stamps each expected item with that due cycle. The monitor compares the item on the falling edge of exactly that cycle, and an item found past its cycle counts as a mismatch. During a strobe's low phase, an item is due in every cycle, so the full width of each cascade pulse is compared and not just its start.

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_strobe,
  input  logic       dn_strobe,
  input  logic       load_n,
  input  logic [3:0] preset_val,
  input  logic       clr,
  output logic [3:0] digit,
  output logic       carry_n,
  output logic       borrow_n
);
  localparam logic [3:0] MAX_DIGIT = 4'd9;

  logic [SYNC_STAGES-1:0] up_sync, dn_sync;
  logic up_prev, dn_prev;
  logic up_lvl, dn_lvl, up_rise, dn_rise, step_up, step_dn;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_sync <= '1;
      dn_sync <= '1;
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_sync <= {up_sync[SYNC_STAGES-2:0], up_strobe};
      dn_sync <= {dn_sync[SYNC_STAGES-2:0], dn_strobe};
      up_prev <= up_sync[SYNC_STAGES-1];
      dn_prev <= dn_sync[SYNC_STAGES-1];
    end

  assign up_lvl  = up_sync[SYNC_STAGES-1];
  assign dn_lvl  = dn_sync[SYNC_STAGES-1];
  assign up_rise = up_lvl & ~up_prev;
  assign dn_rise = dn_lvl & ~dn_prev;
  assign step_up = up_rise & dn_lvl & ~dn_rise;
  assign step_dn = dn_rise & up_lvl & ~up_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        digit <= 4'd0;
    else if (clr)      digit <= 4'd0;
    else if (!load_n)  digit <= preset_val;
    else if (step_up)  digit <= (digit >= MAX_DIGIT) ? 4'd0 : digit + 4'd1;
    else if (step_dn)  digit <= (digit == 4'd0) ? MAX_DIGIT : digit - 4'd1;

  assign carry_n  = ~((digit == MAX_DIGIT) & ~up_lvl);
  assign borrow_n = ~((digit == 4'd0) & ~dn_lvl);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> digit == 4'd0);
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> digit == $past(preset_val));
  p_wrap_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && dn_lvl && !dn_rise && digit == MAX_DIGIT) |=> digit == 4'd0);
  p_wrap_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dn_rise && up_lvl && !up_rise && digit == 4'd0) |=> digit == MAX_DIGIT);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && ((up_rise && dn_rise) || (up_rise && !dn_lvl) || (dn_rise && !up_lvl))) |=> $stable(digit));
  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> digit == MAX_DIGIT);
  p_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> digit == 4'd0);
  p_range_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && step_up && digit > MAX_DIGIT) |=> digit == 4'd0);
  p_cascade_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (carry_n && borrow_n));
endmodule

// File: tb/bcd_updown_counter_bench.sv
module bcd_updown_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_strobe = 1'b1, dn_strobe = 1'b1, load_n = 1'b1, clr = 1'b0;
  logic [3:0] preset_val = 4'd0;
  logic [3:0] digit;
  logic carry_n, borrow_n;

  typedef struct {
    int         due;
    logic [3:0] d;
    logic       c;
    logic       b;
    string      tag;
  } item_t;

  item_t sb[$];
  item_t it;
  int cyc = 0, n_chk = 0, n_bad = 0;
  logic [3:0] m = 4'd0;

  bcd_updown_counter u_bcd_updown_counter (
    .clk(clk), .rst_n(rst_n), .up_strobe(up_strobe), .dn_strobe(dn_strobe),
    .load_n(load_n), .preset_val(preset_val), .clr(clr),
    .digit(digit), .carry_n(carry_n), .borrow_n(borrow_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      n_chk++;
      if (it.due != cyc || digit !== it.d || carry_n !== it.c || borrow_n !== it.b) begin
        n_bad++;
        $display("FAIL %s cyc %0d: got digit=%0d carry_n=%b borrow_n=%b, expected digit=%0d carry_n=%b borrow_n=%b (due %0d)",
                 it.tag, cyc, digit, carry_n, borrow_n, it.d, it.c, it.b, it.due);
      end
    end

  function automatic logic [3:0] inc(input logic [3:0] v);
    return (v >= 4'd9) ? 4'd0 : v + 4'd1;
  endfunction
  function automatic logic [3:0] dec(input logic [3:0] v);
    return (v == 4'd0) ? 4'd9 : v - 4'd1;
  endfunction

  task automatic push(input int due, input logic [3:0] d, input logic c, input logic b, input string tag);
    item_t x;
    x.due = due; x.d = d; x.c = c; x.b = b; x.tag = tag;
    sb.push_back(x);
  endtask

  // R1/R3/R7: up pulse of w cycles; carry compared every cycle of the low phase
  task automatic pulse_up(input int w);
    int c0;
    @(negedge clk); c0 = cyc; up_strobe = 1'b0;
    push(c0 + 1, m, 1'b1, 1'b1, "R3 cascade not yet moved");
    for (int k = 2; k <= w + 1; k++) push(c0 + k, m, (m == 4'd9) ? 1'b0 : 1'b1, 1'b1, "R7 carry low phase");
    repeat (w) @(negedge clk);
    c0 = cyc; up_strobe = 1'b1;
    push(c0 + 2, m, 1'b1, 1'b1, "R3 digit not yet moved");
    m = inc(m);
    push(c0 + 3, m, 1'b1, 1'b1, "R1 up step");
    repeat (5) @(negedge clk);
  endtask

  // R2/R3/R8: down pulse of w cycles
  task automatic pulse_dn(input int w);
    int c0;
    @(negedge clk); c0 = cyc; dn_strobe = 1'b0;
    push(c0 + 1, m, 1'b1, 1'b1, "R3 cascade not yet moved");
    for (int k = 2; k <= w + 1; k++) push(c0 + k, m, 1'b1, (m == 4'd0) ? 1'b0 : 1'b1, "R8 borrow low phase");
    repeat (w) @(negedge clk);
    c0 = cyc; dn_strobe = 1'b1;
    push(c0 + 2, m, 1'b1, 1'b1, "R3 digit not yet moved");
    m = dec(m);
    push(c0 + 3, m, 1'b1, 1'b1, "R2 down step");
    repeat (5) @(negedge clk);
  endtask

  task automatic do_load(input logic [3:0] v);
    @(negedge clk); load_n = 1'b0; preset_val = v;
    push(cyc + 1, v, 1'b1, 1'b1, "R5 preset");
    m = v;
    @(negedge clk); load_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1; load_n = 1'b0; preset_val = 4'd6;
    push(cyc + 1, 4'd0, 1'b1, 1'b1, "R4 clear over load");
    m = 4'd0;
    @(negedge clk); clr = 1'b0; load_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout at cyc %0d, expected completion", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, 4'd0, 1'b1, 1'b1, "R10 reset state");
    repeat (2) @(negedge clk);

    do_clear();
    do_load(4'd7);
    repeat (5) pulse_up(2);           // 8 9 0 1 2
    repeat (5) pulse_dn(3);           // 1 0 9 8 7
    pulse_up(4); pulse_up(1);         // 8 9
    pulse_up(3);                      // wide carry pulse, wraps to 0
    pulse_dn(2);                      // wide borrow pulse, wraps to 9

    // R6: both strobes rise together
    @(negedge clk); up_strobe = 1'b0; dn_strobe = 1'b0;
    repeat (3) @(negedge clk);
    c0 = cyc; up_strobe = 1'b1; dn_strobe = 1'b1;
    push(c0 + 3, m, 1'b1, 1'b1, "R6 simultaneous rise holds");
    repeat (5) @(negedge clk);

    // R6: up rises while down is low, then down rises alone
    do_load(4'd5);
    @(negedge clk); dn_strobe = 1'b0;
    repeat (3) @(negedge clk); up_strobe = 1'b0;
    repeat (3) @(negedge clk);
    c0 = cyc; up_strobe = 1'b1;
    push(c0 + 3, m, 1'b1, 1'b1, "R6 up rise with down low holds");
    repeat (4) @(negedge clk);
    c0 = cyc; dn_strobe = 1'b1;
    m = dec(m);
    push(c0 + 3, m, 1'b1, 1'b1, "R2 down step after hold");
    repeat (5) @(negedge clk);

    // R5: load held low across an up edge
    @(negedge clk); c0 = cyc; load_n = 1'b0; preset_val = 4'd4; up_strobe = 1'b0;
    repeat (2) @(negedge clk); up_strobe = 1'b1;
    repeat (4) @(negedge clk); load_n = 1'b1;
    m = 4'd4;
    push(c0 + 7, m, 1'b1, 1'b1, "R5 load ignores up edge");
    repeat (3) @(negedge clk);

    // R4: clear over an up edge
    @(negedge clk); c0 = cyc; clr = 1'b1; up_strobe = 1'b0;
    repeat (2) @(negedge clk); up_strobe = 1'b1;
    repeat (4) @(negedge clk); clr = 1'b0;
    m = 4'd0;
    push(c0 + 7, m, 1'b1, 1'b1, "R4 clear ignores up edge");
    repeat (3) @(negedge clk);

    // R9: out-of-range presets
    do_load(4'd12);
    pulse_up(2);                      // 0
    do_load(4'd14);
    repeat (6) pulse_dn(1);           // 13 12 11 10 9 8
    do_load(4'd15);
    pulse_up(1);                      // 0

    repeat (5) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R3: got %0d pending items, expected 0", sb.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule